// File: doc/BRIEF.md
# Vector High-Half Narrowing Subtractor

This block is the execute stage of a vector unit for a family of narrowing subtract operations. It takes two 128-bit source vectors and views each as a row of double-width lanes. It subtracts each lane of the second source from the matching lane of the first. From every difference it keeps only the upper half, and it packs those halves into a 64-bit narrow result. A 2-bit size code picks the narrow element width: 8, 16 or 32 bits. The full difference width is therefore 16, 32 or 64 bits.

The caller also supplies the current 128-bit destination value and a part bit. With the part bit clear, the narrow result fills the lower 64 bits and the upper 64 bits become zero. With the part bit set, the result fills the upper 64 bits and the lower 64 bits pass through unchanged. A round enable adds half of a narrow unit before the upper half is taken, so the rounding form of the operation shares the same hardware. Results appear one clock after the request, together with a write enable. Size code 3 raises an undefined-operation flag and suppresses the write.

Top module: `simd_subhi_narrow`

## Requirements
- R1: Size code 0, 1 and 2 select narrow width W = 8, 16 and 32. Wide lane e is read from source bits [e*2W +: 2W]. Narrow element e is placed at result bits [e*W +: W], for e from 0 to 64/W-1.
- R2: With rnd_en=0, narrow element e equals bits [2W-1:W] of (lane_a - lane_b) mod 2^(2W). This is truncation with no increment.
- R3: With rnd_en=1, narrow element e equals bits [2W-1:W] of (lane_a - lane_b + 2^(W-1)) mod 2^(2W).
- R4: With part_hi=0 and a legal size, dst_new[63:0] is the narrow result and dst_new[127:64] is zero.
- R5: With part_hi=1 and a legal size, dst_new[127:64] is the narrow result and dst_new[63:0] equals dst_old[63:0] of the same request.
- R6: Size code 3 sets undef=1 and dst_we=0, and dst_new repeats dst_old unchanged. A legal size gives undef=0 and dst_we=1.
- R7: A request with req_valid=1 produces rsp_valid=1 on the following cycle. A cycle with req_valid=0 produces rsp_valid=0, dst_we=0 and undef=0 on the following cycle.
- R8: While rst is high, rsp_valid, undef, dst_we and dst_new are all zero.
- R9: A borrow never crosses a lane and results never saturate. For example, 0 minus 1 gives an all-ones narrow element while the neighbouring lanes are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| size_code | input | 2 | Narrow width select (0:8, 1:16, 2:32, 3:illegal) |
| part_hi | input | 1 | 0: write low half and clear high half; 1: write high half and keep low half |
| rnd_en | input | 1 | Add half a narrow unit before narrowing |
| src_a | input | 128 | Minuend vector |
| src_b | input | 128 | Subtrahend vector |
| dst_old | input | 128 | Current destination value |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| undef | output | 1 | Illegal size code seen |
| dst_we | output | 1 | Destination write enable |
| dst_new | output | 128 | New destination value |

## Verification
The hardest case to reach from the ports is a borrow that would spill across a lane boundary. A random operand seldom puts an all-zero lane beside a non-zero one in exactly the lane the subtraction borrows from. The stimulus therefore uses structured operands such as zero minus one, all-ones, the most negative lane value and one-hot lane constants. Each of these is replicated per lane for the active width, and every operand is swept over each size, both part settings and both rounding settings. Random operands fill in the remaining space.

// File: rtl/shn_pkg.sv
package shn_pkg;

    localparam int VEC_W   = 128;
    localparam int NUM_SZ  = 3;

    typedef enum logic [1:0] {
        SZ_N8   = 2'd0,
        SZ_N16  = 2'd1,
        SZ_N32  = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef struct packed {
        logic               valid;
        logic               undef;
        logic               we;
        logic [VEC_W-1:0]   dst;
    } shn_rsp_t;

    function automatic logic size_legal(input logic [1:0] code);
        return code != SZ_BAD;
    endfunction

endpackage

// File: rtl/shn_lane.sv
module shn_lane #(
    parameter int NW = 8
) (
    input  logic [2*NW-1:0] a,
    input  logic [2*NW-1:0] b,
    input  logic            rnd,
    output logic [NW-1:0]   hi
);
    localparam int WW = 2 * NW;

    logic [WW-1:0] rinc;
    logic [WW-1:0] diff;

    assign rinc = rnd ? (WW'(1) << (NW - 1)) : '0;
    assign diff = a - b + rinc;
    assign hi   = diff[WW-1:NW];
endmodule

// File: rtl/shn_size_path.sv
module shn_size_path #(
    parameter int NW    = 8,
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic               rnd,
    output logic [VEC_W/2-1:0] res
);
    localparam int RES_W = VEC_W / 2;
    localparam int LANES = RES_W / NW;
    localparam int WW    = 2 * NW;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        shn_lane #(.NW(NW)) u_lane (
            .a   (src_a[e*WW +: WW]),
            .b   (src_b[e*WW +: WW]),
            .rnd (rnd),
            .hi  (res[e*NW +: NW])
        );
    end
endmodule

// File: rtl/shn_dest_merge.sv
module shn_dest_merge #(
    parameter int VEC_W = 128
) (
    input  logic                part_hi,
    input  logic [VEC_W/2-1:0]  res,
    input  logic [VEC_W-1:0]    dst_old,
    output logic [VEC_W-1:0]    dst_new
);
    localparam int RES_W = VEC_W / 2;

    always_comb begin
        if (part_hi) dst_new = {res, dst_old[RES_W-1:0]};
        else         dst_new = {{RES_W{1'b0}}, res};
    end
endmodule

// File: rtl/simd_subhi_narrow.sv
module simd_subhi_narrow
    import shn_pkg::*;
#(
    parameter int VEC_W = shn_pkg::VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       size_code,
    input  logic             part_hi,
    input  logic             rnd_en,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] dst_old,
    output logic             rsp_valid,
    output logic             undef,
    output logic             dst_we,
    output logic [VEC_W-1:0] dst_new
);
    localparam int RES_W = VEC_W / 2;

    logic [RES_W-1:0] res_by_size [NUM_SZ];
    logic [RES_W-1:0] res_sel;
    logic [VEC_W-1:0] merged;
    logic             legal;
    shn_rsp_t         rsp_q;

    for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
        shn_size_path #(.NW(8 << k), .VEC_W(VEC_W)) u_path (
            .src_a (src_a),
            .src_b (src_b),
            .rnd   (rnd_en),
            .res   (res_by_size[k])
        );
    end

    assign legal = size_legal(size_code);

    always_comb begin
        case (size_e'(size_code))
            SZ_N8:   res_sel = res_by_size[0];
            SZ_N16:  res_sel = res_by_size[1];
            SZ_N32:  res_sel = res_by_size[2];
            default: res_sel = '0;
        endcase
    end

    shn_dest_merge #(.VEC_W(VEC_W)) u_merge (
        .part_hi (part_hi),
        .res     (res_sel),
        .dst_old (dst_old),
        .dst_new (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            rsp_q.undef <= req_valid & ~legal;
            rsp_q.we    <= req_valid & legal;
            if (req_valid) rsp_q.dst <= legal ? merged : dst_old;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign undef     = rsp_q.undef;
    assign dst_we    = rsp_q.we;
    assign dst_new   = rsp_q.dst;
endmodule

// File: rtl/shn_checker.sv
module shn_checker #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       size_code,
    input logic             part_hi,
    input logic [VEC_W-1:0] dst_old,
    input logic             rsp_valid,
    input logic             undef,
    input logic             dst_we,
    input logic [VEC_W-1:0] dst_new
);
    localparam int RES_W = VEC_W / 2;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                            // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !dst_we && !undef));                   // R7
    AST_BAD_SIZE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (req_valid && size_code == 2'd3) |=> (undef && !dst_we));            // R6
    AST_BAD_SIZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && size_code == 2'd3) |=> dst_new == $past(dst_old));     // R6
    AST_WE_XOR_UNDEF: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (dst_we != undef));                                    // R6
    AST_LOW_CLEARS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (req_valid && size_code != 2'd3 && !part_hi)
            |=> dst_new[VEC_W-1:RES_W] == '0);                               // R4
    AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && size_code != 2'd3 && part_hi)
            |=> dst_new[RES_W-1:0] == $past(dst_old[RES_W-1:0]));            // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        disable iff (1'b0) rst |=> (!rsp_valid && !dst_we && !undef && dst_new == '0)); // R8
endmodule

bind simd_subhi_narrow shn_checker #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .size_code (size_code),
    .part_hi   (part_hi),
    .dst_old   (dst_old),
    .rsp_valid (rsp_valid),
    .undef     (undef),
    .dst_we    (dst_we),
    .dst_new   (dst_new)
);

// File: tb/sim_simd_subhi_narrow.sv
module sim_simd_subhi_narrow;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [1:0]   size_code = 2'd0;
    logic         part_hi = 1'b0;
    logic         rnd_en = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] dst_old = '0;
    logic         rsp_valid, undef, dst_we;
    logic [127:0] dst_new;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    simd_subhi_narrow u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .size_code(size_code),
        .part_hi(part_hi), .rnd_en(rnd_en), .src_a(src_a), .src_b(src_b),
        .dst_old(dst_old), .rsp_valid(rsp_valid), .undef(undef),
        .dst_we(dst_we), .dst_new(dst_new)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] expect_dst(input int sz, input bit ph, input bit rn,
                                                input logic [127:0] a, input logic [127:0] b,
                                                input logic [127:0] old);
        int es = 8 << sz;
        logic [127:0] mask = (128'd1 << (2 * es)) - 128'd1;
        logic [127:0] inc  = rn ? (128'd1 << (es - 1)) : 128'd0;
        logic [63:0]  r    = '0;
        for (int e = 0; e < 64 / es; e++) begin
            logic [127:0] wa = (a >> (e * 2 * es)) & mask;
            logic [127:0] wb = (b >> (e * 2 * es)) & mask;
            logic [127:0] d  = (wa - wb + inc) & mask;
            r = r | 64'((d >> es) << (e * es));
        end
        return ph ? {r, old[63:0]} : {64'd0, r};
    endfunction

    function automatic logic [127:0] replicate(input int sz, input logic [63:0] lane);
        int ww = 16 << sz;
        logic [127:0] m = (128'd1 << ww) - 128'd1;
        logic [127:0] v = '0;
        for (int e = 0; e < 128 / ww; e++) v = v | (((128'(lane)) & m) << (e * ww));
        return v;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic run_op(input int sz, input bit ph, input bit rn,
                          input logic [127:0] a, input logic [127:0] b, input logic [127:0] old,
                          input string tag);
        @(negedge clk);
        req_valid = 1'b1; size_code = 2'(sz); part_hi = ph; rnd_en = rn;
        src_a = a; src_b = b; dst_old = old;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R7 valid"}, 128'(rsp_valid), 128'd1);
        if (sz == 3) begin
            chk("R6 undef", 128'(undef), 128'd1);
            chk("R6 we", 128'(dst_we), 128'd0);
            chk("R6 dst held", dst_new, old);
        end else begin
            chk({tag, " R6 we"}, 128'({undef, dst_we}), 128'd1);
            chk(tag, dst_new, expect_dst(sz, ph, rn, a, b, old));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 rsp_valid", 128'(rsp_valid), 128'd0);
        chk("R8 flags", 128'({undef, dst_we}), 128'd0);
        chk("R8 dst_new", dst_new, 128'd0);
        rst = 1'b0;

        for (int sz = 0; sz < 3; sz++) begin
            int es = 8 << sz;
            logic [63:0] ones = (es == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * es)) - 64'd1);
            logic [63:0] mneg = 64'd1 << (2 * es - 1);
            logic [63:0] half = 64'd1 << (es - 1);
            for (int ph = 0; ph < 2; ph++) begin
                for (int rn = 0; rn < 2; rn++) begin
                    string t = rn ? "R3" : "R2";
                    logic [127:0] old = rnd128();
                    // R9: zero minus one borrows within lane only
                    run_op(sz, ph[0], rn[0], '0, replicate(sz, 64'd1), old, "R9 zero-one");
                    run_op(sz, ph[0], rn[0], replicate(sz, ones), '0, old, {t, " ones"});
                    run_op(sz, ph[0], rn[0], replicate(sz, mneg), replicate(sz, 64'd1), old, "R9 mneg-1");
                    run_op(sz, ph[0], rn[0], '0, replicate(sz, mneg), old, "R9 0-mneg");
                    run_op(sz, ph[0], rn[0], replicate(sz, half), '0, old, "R3 half");
                    run_op(sz, ph[0], rn[0], replicate(sz, half - 64'd1), '0, old, "R3 below half");
                    run_op(sz, ph[0], rn[0], replicate(sz, ones), replicate(sz, ones), old, {t, " equal"});
                    // R1: one-hot lane marks lane placement
                    for (int e = 0; e < 64 / es; e++)
                        run_op(sz, ph[0], rn[0], 128'd1 << (e * 2 * es + es), '0, old, "R1 lane");
                    for (int k = 0; k < 8; k++)
                        run_op(sz, ph[0], rn[0], rnd128(), rnd128(), rnd128(),
                               ph ? "R5 random" : "R4 random");
                end
            end
        end

        // R6: illegal size in both part settings
        run_op(3, 1'b0, 1'b0, rnd128(), rnd128(), rnd128(), "R6");
        run_op(3, 1'b1, 1'b1, rnd128(), rnd128(), rnd128(), "R6");

        // R7: idle cycle clears response strobes
        @(negedge clk);
        chk("R7 idle valid", 128'(rsp_valid), 128'd0);
        chk("R7 idle flags", 128'({undef, dst_we}), 128'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule